// File: doc/BRIEF.md
# Reply Comparison Pulse Generator

This block produces the expected reply pulse train against which a reply tester compares the pulses returned by a secondary-radar transponder. An arm strobe opens an acceptance window. The first framing pulse (F1) that arrives while the window is open becomes time zero. A free-running tick counter then stands in for a tapped delay line. Decodes on the counter mark twelve information slots, the second framing pulse (F2) and the identification-of-position (I/P) slot.

The twelve information slots are masked by a code-select word. F2 and I/P are always produced. Each slot that is produced appears as a fixed-width pulse on an active-high output and, at the same time, on an active-low complement output. These feed a downstream error detector.

A re-arm point part-way through each train reopens the window, so the next received F1 starts another cycle. The test type sets how many cycles make up one test: one, two or four. After the final cycle a done strobe is raised and the window stays closed until the next arm strobe.

Top module: `reply_compare_gen`

## Requirements
- R1: While reset is asserted and after it is released, compPos is 0, compNeg is 1, acceptEnable is 0 and trainDone is 0 until the first arm strobe.
- R2: An armPulse sampled at a clock edge:
  - drives acceptEnable to 1 after that edge;
  - latches testType;
  - cancels any train in progress, including a pulse currently on the outputs, so no further slot pulse follows;
  - takes priority over a framePulse sampled at the same edge, which is then ignored.
- R3: A framePulse sampled while acceptEnable is 1 (and armPulse is 0) is accepted at that edge A, and acceptEnable is 0 after it. A framePulse sampled while acceptEnable is 0 is ignored.
- R4: The output pulse for a slot at tick offset P rises after edge A+P+1 and stays high for PULSE_TICKS cycles (default 10). The default offsets are:
  - information bit k (k = 0..11): 29*(k+1);
  - F2: 406;
  - I/P: 493.
- R5: Information bit k is produced only when codeSelect[k] is 1. F2 and I/P are produced in every cycle regardless of codeSelect.
- R6: compNeg is the complement of compPos in every cycle.
- R7: If more cycles of the test remain, acceptEnable returns to 1 after edge A+441 (re-arm at tick 440). It stays 1 until an F1 is accepted or an arm arrives.
- R8: testType encodes the cycle count:
  - 0 (system test): 1 cycle;
  - 1 (identity test, not mode 1): 1 cycle;
  - 2 (mode 1 identity test): 2 cycles;
  - 3 (emergency test): 4 cycles.
  The value is latched at the arm strobe, and later changes have no effect until the next arm.
- R9: The first cycle always produces the code-masked information slots. In a mode 1 identity test, the second cycle produces them as well. In an emergency test, cycles 2 to 4 produce only F2 and I/P.
- R10: trainDone is a one-cycle strobe raised after the edge at which the final cycle's I/P pulse rises. acceptEnable remains 0 after it until the next arm.
- R11: An F1 accepted while the previous cycle is still counting restarts the timing from that edge:
  - slots of the old cycle whose offset has not yet been reached are dropped;
  - an old-cycle slot that is decoded at the same edge as the new F1 is still produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one delay tick (0.05 us at the default rate) |
| rstN | input | 1 | Asynchronous active-low reset |
| armPulse | input | 1 | One-cycle strobe that opens acceptance and starts a new test |
| framePulse | input | 1 | Received F1 framing pulse, one cycle wide |
| codeSelect | input | CODE_BITS | Per-slot enable for the information positions |
| testType | input | 2 | Test type; sets the number of cycles |
| compPos | output | 1 | Comparison pulse, active high |
| compNeg | output | 1 | Comparison pulse, active low |
| acceptEnable | output | 1 | High while the next F1 would be accepted |
| trainDone | output | 1 | One-cycle strobe when the last cycle's I/P pulse starts |

## Verification
Every result is due at a fixed count of edges from the edge that sampled the accepted F1:
- a slot at offset P rises after edge A+P+1;
- the re-arm lands after edge A+441;
- the done strobe coincides with the final I/P rise after edge A+494;
- an arm takes effect after the very edge that samples it.

The bench reference model counts edges from the accepted F1 and schedules each expected pulse for the edge where it is due. It then compares all four outputs at the falling edge of every cycle, after the rising edge has settled.

Directed scenarios put a second F1 exactly on the I/P decode edge, or early just after re-arm. They also abort a train in the middle of a pulse. After each scenario, the bench tallies pulse rises and done strobes against counts derived from the code word.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  localparam int CYCLE_W = 3;

  typedef enum logic [1:0] {
    TEST_SYSTEM      = 2'd0,
    TEST_IDENT       = 2'd1,
    TEST_MODE1_IDENT = 2'd2,
    TEST_EMERGENCY   = 2'd3
  } testMode_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic start;      // accepted F1: restart the tick counter
    logic abort;      // arm strobe: stop and clear everything
    logic fullTrain;  // information slots allowed in this cycle
  } ctrlStrobes_t;

  // Timing events from the datapath back to the control
  typedef struct packed {
    logic rearmPoint;
    logic finalPoint;
  } dpEvents_t;

  function automatic logic [CYCLE_W-1:0] cyclesFor(testMode_t mode);
    case (mode)
      TEST_MODE1_IDENT: cyclesFor = CYCLE_W'(2);
      TEST_EMERGENCY:   cyclesFor = CYCLE_W'(4);
      default:          cyclesFor = CYCLE_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/rcg_control.sv
module rcg_control
  import rcg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         armPulse,
  input  logic         framePulse,
  input  logic [1:0]   testType,
  input  dpEvents_t    events,
  output ctrlStrobes_t strobes,
  output logic         acceptEnable,
  output logic         trainDone
);

  testMode_t          typeQ;
  logic [CYCLE_W-1:0] cycleCount;
  logic               acceptQ;
  logic               doneQ;
  logic               accept;
  logic               moreToCome;
  logic               lastCycle;

  assign accept     = framePulse && acceptQ && !armPulse;
  assign moreToCome = cycleCount < cyclesFor(typeQ);
  assign lastCycle  = cycleCount == cyclesFor(typeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptQ    <= 1'b0;
      cycleCount <= '0;
      typeQ      <= TEST_SYSTEM;
      doneQ      <= 1'b0;
    end else if (armPulse) begin
      acceptQ    <= 1'b1;
      cycleCount <= '0;
      typeQ      <= testMode_t'(testType);
      doneQ      <= 1'b0;
    end else begin
      doneQ <= events.finalPoint && lastCycle;
      if (accept) begin
        acceptQ    <= 1'b0;
        cycleCount <= cycleCount + 1'b1;
      end else if (events.rearmPoint && moreToCome) begin
        acceptQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.start     = accept;
    strobes.abort     = armPulse;
    strobes.fullTrain = (cycleCount == CYCLE_W'(1)) || (typeQ == TEST_MODE1_IDENT);
  end

  assign acceptEnable = acceptQ;
  assign trainDone    = doneQ;

endmodule

// File: rtl/rcg_datapath.sv
module rcg_datapath
  import rcg_pkg::*;
#(
  parameter int CODE_BITS   = 12,
  parameter int SLOT_TICKS  = 29,
  parameter int F2_TICK     = 406,
  parameter int IP_TICK     = 493,
  parameter int REARM_TICK  = 440,
  parameter int PULSE_TICKS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [CODE_BITS-1:0] codeSelect,
  output dpEvents_t            events,
  output logic                 compPos,
  output logic                 compNeg
);

  localparam int TIMER_W = $clog2(IP_TICK + 1);
  localparam int WIDTH_W = $clog2(PULSE_TICKS + 1);
  localparam logic [TIMER_W-1:0] F2_AT    = TIMER_W'(F2_TICK);
  localparam logic [TIMER_W-1:0] IP_AT    = TIMER_W'(IP_TICK);
  localparam logic [TIMER_W-1:0] REARM_AT = TIMER_W'(REARM_TICK);

  logic [TIMER_W-1:0]   timer;
  logic                 running;
  logic [CODE_BITS-1:0] infoHit;
  logic                 f2Hit;
  logic                 ipHit;
  logic                 anyHit;
  logic [WIDTH_W-1:0]   widthCnt;
  logic                 posQ;
  logic                 negQ;

  // Tick counter standing in for the tapped delay line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer   <= '0;
      running <= 1'b0;
    end else if (strobes.abort) begin
      timer   <= '0;
      running <= 1'b0;
    end else if (strobes.start) begin
      timer   <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (timer == IP_AT) running <= 1'b0;
      else                timer   <= timer + 1'b1;
    end
  end

  // One tap decode per information slot
  for (genvar k = 0; k < CODE_BITS; k++) begin : g_infoTap
    localparam logic [TIMER_W-1:0] SLOT_AT = TIMER_W'((k + 1) * SLOT_TICKS);
    assign infoHit[k] = running && (timer == SLOT_AT) && codeSelect[k] && strobes.fullTrain;
  end

  assign f2Hit  = running && (timer == F2_AT);
  assign ipHit  = running && (timer == IP_AT);
  assign anyHit = (|infoHit) || f2Hit || ipHit;

  assign events.rearmPoint = running && (timer == REARM_AT);
  assign events.finalPoint = ipHit;

  // Fixed-width pulse former with complementary outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ     <= 1'b0;
      negQ     <= 1'b1;
      widthCnt <= '0;
    end else if (strobes.abort) begin
      posQ     <= 1'b0;
      negQ     <= 1'b1;
      widthCnt <= '0;
    end else if (anyHit) begin
      posQ     <= 1'b1;
      negQ     <= 1'b0;
      widthCnt <= WIDTH_W'(PULSE_TICKS - 1);
    end else if (posQ) begin
      if (widthCnt == '0) begin
        posQ <= 1'b0;
        negQ <= 1'b1;
      end else begin
        widthCnt <= widthCnt - 1'b1;
      end
    end
  end

  assign compPos = posQ;
  assign compNeg = negQ;

endmodule

// File: rtl/reply_compare_gen.sv
module reply_compare_gen
  import rcg_pkg::*;
#(
  parameter int CODE_BITS   = 12,
  parameter int SLOT_TICKS  = 29,
  parameter int F2_TICK     = 406,
  parameter int IP_TICK     = 493,
  parameter int REARM_TICK  = 440,
  parameter int PULSE_TICKS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 armPulse,
  input  logic                 framePulse,
  input  logic [CODE_BITS-1:0] codeSelect,
  input  logic [1:0]           testType,
  output logic                 compPos,
  output logic                 compNeg,
  output logic                 acceptEnable,
  output logic                 trainDone
);

  ctrlStrobes_t strobes;
  dpEvents_t    events;

  rcg_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .armPulse     (armPulse),
    .framePulse   (framePulse),
    .testType     (testType),
    .events       (events),
    .strobes      (strobes),
    .acceptEnable (acceptEnable),
    .trainDone    (trainDone)
  );

  rcg_datapath #(
    .CODE_BITS   (CODE_BITS),
    .SLOT_TICKS  (SLOT_TICKS),
    .F2_TICK     (F2_TICK),
    .IP_TICK     (IP_TICK),
    .REARM_TICK  (REARM_TICK),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .codeSelect (codeSelect),
    .events     (events),
    .compPos    (compPos),
    .compNeg    (compNeg)
  );

endmodule

// File: rtl/rcg_checker.sv
module rcg_checker #(
  parameter int PULSE_TICKS = 10
) (
  input logic clk,
  input logic rstN,
  input logic armPulse,
  input logic framePulse,
  input logic acceptEnable,
  input logic compPos,
  input logic compNeg,
  input logic trainDone
);

  logic [15:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        highRun <= '0;
    else if (compPos) highRun <= highRun + 1'b1;
    else              highRun <= '0;
  end

  assert_arm_opens_R2: assert property (@(posedge clk) disable iff (!rstN)
    armPulse |=> (acceptEnable && !compPos));

  assert_accept_closes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (acceptEnable && framePulse && !armPulse) |=> !acceptEnable);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(compPos) && !$past(armPulse)) |-> (highRun == 16'(PULSE_TICKS)));

  assert_complement_R6: assert property (@(posedge clk) disable iff (!rstN)
    compNeg == !compPos);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |=> !trainDone);

  assert_done_with_ip_R10: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |-> (compPos && !acceptEnable));

endmodule

bind reply_compare_gen rcg_checker #(.PULSE_TICKS(PULSE_TICKS)) u_rcgChecker (
  .clk          (clk),
  .rstN         (rstN),
  .armPulse     (armPulse),
  .framePulse   (framePulse),
  .acceptEnable (acceptEnable),
  .compPos      (compPos),
  .compNeg      (compNeg),
  .trainDone    (trainDone)
);

// File: tb/test_reply_compare_gen.sv
`timescale 1ns/1ps
module test_reply_compare_gen;

  localparam int CODE_BITS = 12;
  localparam int SLOT = 29;
  localparam int F2T = 406;
  localparam int IPT = 493;
  localparam int REARM = 440;
  localparam int PW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armPulse = 1'b0;
  logic framePulse = 1'b0;
  logic [CODE_BITS-1:0] codeSelect = '0;
  logic [1:0] testType = 2'd0;
  logic compPos, compNeg, acceptEnable, trainDone;

  int checks = 0;
  int failures = 0;
  int riseCount = 0;
  int doneCount = 0;
  bit prevPos = 0;
  bit live = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  reply_compare_gen i_reply_compare_gen (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .framePulse(framePulse),
    .codeSelect(codeSelect), .testType(testType), .compPos(compPos),
    .compNeg(compNeg), .acceptEnable(acceptEnable), .trainDone(trainDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cyclesOf(int t);
    if (t == 2) return 2;
    if (t == 3) return 4;
    return 1;
  endfunction

  // ---------------- reference model: edges counted from the accepted F1
  int edgeNo, mLast, mCount, mType, t;
  bit mAccept, mDone, oldAccept, full;
  int starts[$];

  always @(posedge clk) begin
    if (!rstN) begin
      edgeNo = 0; mLast = -1; mCount = 0; mType = 0;
      mAccept = 0; mDone = 0; starts.delete();
    end else begin
      edgeNo++;
      oldAccept = mAccept;
      if (armPulse) begin
        mAccept = 1; mCount = 0; mType = testType; mDone = 0;
        mLast = -1; starts.delete();
      end else begin
        mDone = 0;
        if (mLast >= 0) begin
          t = edgeNo - 1 - mLast;
          if (t >= 0 && t <= IPT) begin
            full = (mCount == 1) || (mType == 2);
            for (int k = 0; k < CODE_BITS; k++)
              if (t == (k + 1) * SLOT && codeSelect[k] && full) starts.push_back(edgeNo);
            if (t == F2T || t == IPT) starts.push_back(edgeNo);
            if (t == IPT && mCount == cyclesOf(mType)) mDone = 1;
          end
        end
        if (framePulse && oldAccept) begin
          mAccept = 0; mCount++; mLast = edgeNo;
        end else if (mLast >= 0 && (edgeNo - 1 - mLast) == REARM && mCount < cyclesOf(mType)) begin
          mAccept = 1;
        end
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (live && !finished) begin
      bit expPos;
      expPos = 0;
      foreach (starts[i])
        if (starts[i] <= edgeNo && edgeNo <= starts[i] + PW - 1) expPos = 1;
      check(compPos == expPos, "R4 compPos", compPos, expPos);
      check(compNeg == !expPos, "R6 compNeg", compNeg, !expPos);
      check(acceptEnable == mAccept, "R7 acceptEnable", acceptEnable, mAccept);
      check(trainDone == mDone, "R10 trainDone", trainDone, mDone);
      if (compPos && !prevPos) riseCount++;
      if (trainDone) doneCount++;
      prevPos = compPos;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic armWith(input logic [1:0] ty);
    @(negedge clk);
    testType = ty; armPulse = 1'b1;
    @(negedge clk);
    armPulse = 1'b0;
  endtask

  task automatic pulseF1();
    @(negedge clk);
    framePulse = 1'b1;
    @(negedge clk);
    framePulse = 1'b0;
  endtask

  task automatic clearCounts();
    riseCount = 0; doneCount = 0;
  endtask

  task automatic finish();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    int pop;
    // R1: reset state
    waitN(4);
    check(compPos == 0, "R1 compPos in reset", compPos, 0);
    check(compNeg == 1, "R1 compNeg in reset", compNeg, 1);
    check(acceptEnable == 0, "R1 acceptEnable in reset", acceptEnable, 0);
    rstN = 1'b1;
    live = 1;
    waitN(3);
    check(trainDone == 0 && acceptEnable == 0, "R1 idle after reset", acceptEnable, 0);

    // R3: F1 without arm is ignored
    clearCounts();
    pulseF1();
    waitN(600);
    check(riseCount == 0, "R3 F1 before arm ignored", riseCount, 0);

    // System test: extra F1 ignored, code-masked slots
    codeSelect = 12'hA5C; pop = $countones(12'hA5C);
    clearCounts();
    armWith(2'd0);
    check(acceptEnable == 1, "R2 arm opens acceptance", acceptEnable, 1);
    pulseF1();
    waitN(100);
    pulseF1();
    waitN(450);
    check(riseCount == pop + 2, "R5 system train pulse count", riseCount, pop + 2);
    check(doneCount == 1, "R10 single done", doneCount, 1);
    check(acceptEnable == 0, "R10 stays closed after done", acceptEnable, 0);

    // Identity (non mode 1), empty code: only F2 and I/P
    codeSelect = 12'h000;
    clearCounts();
    armWith(2'd1);
    pulseF1();
    waitN(520);
    check(riseCount == 2, "R5 framing only with empty code", riseCount, 2);

    // Mode 1 identity: two full trains; testType change after arm has no effect
    codeSelect = 12'h3F1; pop = $countones(12'h3F1);
    clearCounts();
    armWith(2'd2);
    testType = 2'd0;
    pulseF1();
    waitN(492);
    pulseF1();
    waitN(520);
    check(riseCount == 2 * (pop + 2), "R9 mode 1 second full train", riseCount, 2 * (pop + 2));
    check(doneCount == 1, "R8 mode 1 done after two cycles", doneCount, 1);

    // Emergency: four cycles, extra ones framing only
    codeSelect = 12'hFFF;
    clearCounts();
    armWith(2'd3);
    pulseF1();
    for (int c = 0; c < 3; c++) begin
      waitN(492);
      pulseF1();
    end
    waitN(520);
    check(riseCount == 14 + 3 * 2, "R9 emergency framing pairs", riseCount, 20);
    check(doneCount == 1, "R8 emergency done after four cycles", doneCount, 1);

    // R11: early second F1 drops pending I/P of the first cycle
    codeSelect = 12'h00F; pop = 4;
    clearCounts();
    armWith(2'd2);
    pulseF1();
    waitN(458);
    pulseF1();
    waitN(520);
    check(riseCount == (pop + 1) + (pop + 2), "R11 early F1 restarts timing", riseCount, 11);

    // R7: mode 1 with no second F1 stays open, no done
    clearCounts();
    armWith(2'd2);
    pulseF1();
    waitN(600);
    check(doneCount == 0, "R7 no done while waiting", doneCount, 0);
    check(acceptEnable == 1, "R7 reopened after re-arm point", acceptEnable, 1);

    // R2: abort in the middle of a pulse
    codeSelect = 12'hFFF;
    armWith(2'd0);
    pulseF1();
    waitN(30);
    check(compPos == 1, "R2 pulse active before abort", compPos, 1);
    armWith(2'd0);
    clearCounts();
    check(compPos == 0, "R2 abort clears output", compPos, 0);
    check(acceptEnable == 1, "R2 abort reopens acceptance", acceptEnable, 1);
    waitN(600);
    check(riseCount == 0, "R2 no pulses after abort", riseCount, 0);

    // R2: F1 coincident with arm is ignored
    clearCounts();
    @(negedge clk);
    testType = 2'd0; armPulse = 1'b1; framePulse = 1'b1;
    @(negedge clk);
    armPulse = 1'b0; framePulse = 1'b0;
    waitN(600);
    check(riseCount == 0, "R2 F1 with arm ignored", riseCount, 0);
    check(acceptEnable == 1, "R2 still open after coincident F1", acceptEnable, 1);
    pulseF1();
    waitN(520);
    check(doneCount == 1, "R3 later F1 accepted", doneCount, 1);

    finish();
  end

endmodule